// File: doc/BRIEF.md
# PC-Card Memory and I/O Strobe Sequencer

This block turns a single access request into the strobe sequence that a PC-card style memory or I/O target expects on a shared external bus. A request carries an address, a read/write flag, a memory-or-I/O space flag, a byte-or-halfword width flag and write data. The block then walks through four phases: address setup, strobe, address hold and completion. It drives two active-low card enables, one for each byte lane, plus an output enable. Four further control lines act as register select, memory write, I/O read and I/O write.

The timing is programmed per access. An address setup count of 0 to 15 cycles and an address hold count of 0 to 15 cycles are given. The strobe width is one cycle plus a base wait count and an extra wait count. The extra count is limited to 50. An external ready input can stretch the final strobe cycle, but only when the summed wait count is non-zero. The block samples the configuration when it accepts a request. All strobes come straight from flip-flops, so they do not glitch.

Top module: `pcard_strobe_seq`

## Requirements
- R1: While reset is applied and after it is released, `busy` and `done` are 0 and every strobe output (`ce_lo_n`, `ce_hi_n`, `oe_n`, `we_n`, `iord_n`, `iowr_n`, `reg_n`) is 1.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and the block is idle. From the next cycle `card_addr` holds the request address. The card enables then stay high for exactly `cfg_setup` cycles, using the `cfg_setup` value sampled at acceptance.
- R3: Card enables are selected by width and by address bit 0. With `req_wide`=1 both enables go low. With `req_wide`=0 and bit 0 = 0 only `ce_lo_n` goes low. With `req_wide`=0 and bit 0 = 1 only `ce_hi_n` goes low.
- R4: For a memory access (`req_io`=0), the strobe phase drives `oe_n` low for a read (`req_write`=0) or `we_n` low for a write (`req_write`=1). `reg_n` stays high, and at most one command line is low at any time.
- R5: For an I/O access (`req_io`=1), the strobe phase drives `iord_n` or `iowr_n` low instead of the memory lines. `reg_n` is low from the first setup cycle through the last hold cycle.
- R6: The strobe phase lasts 1 + `cfg_base_wait` + min(`cfg_extra_wait`, 50) cycles when no ready stretch occurs. The card enables are low during this phase.
- R7: When the summed wait count is non-zero, each cycle in which `card_ready` is 0 during the last strobe cycle repeats that cycle. When the sum is zero, `card_ready` has no effect.
- R8: After the command line rises, the card enables and `card_addr` remain for exactly the sampled `cfg_hold` cycles.
- R9: In the cycle after the last hold cycle (or after the last strobe cycle when the hold count is 0), `done` is 1 for one cycle with both card enables high. The block is idle in the cycle after that.
- R10: On the edge where a read's command line deasserts, `rdata` captures `card_rdata`. Write accesses leave `rdata` unchanged.
- R11: `req_valid` is ignored while `busy` is 1. The current access and its address are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | SETUP_W | Address setup cycles before card enables |
| cfg_hold | input | SETUP_W | Address hold cycles after the command line |
| cfg_base_wait | input | BASE_W | Base wait cycles |
| cfg_extra_wait | input | EXTRA_W | Added wait cycles, limited to 50 |
| card_ready | input | 1 | Target ready; 0 stretches the last strobe cycle |
| card_rdata | input | 16 | Data from the target |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| card_addr | output | AW | Address to the target |
| card_wdata | output | 16 | Write data to the target |
| ce_lo_n | output | 1 | Low byte card enable, active low |
| ce_hi_n | output | 1 | High byte card enable, active low |
| oe_n | output | 1 | Memory output enable, active low |
| we_n | output | 1 | Memory write, active low |
| iord_n | output | 1 | I/O read, active low |
| iowr_n | output | 1 | I/O write, active low |
| reg_n | output | 1 | Register select, active low |
| rdata | output | 16 | Captured read data |

## Verification
The assertions check the following on every cycle:
- the reset state;
- that at most one command line is low;
- that a command line is never low without a card enable;
- that an I/O command always has register select low;
- that the completion pulse lasts one cycle with both enables high;
- that the address holds still throughout an access.

Phase lengths depend on the sampled counts, the limit on the extra wait, and stretching from the ready input. Whether ready is ignored when the sum is zero, and which edge captures read data, can only be shown by the bench scenarios. There, a cycle-by-cycle reference model compares every output against a schedule built from the request.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int unsigned DW = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    // active-high view of the card-side lines
    typedef struct packed {
        logic ce_lo;
        logic ce_hi;
        logic oe;
        logic we;
        logic iord;
        logic iowr;
        logic regsel;
    } strobe_t;
endpackage

// File: rtl/pcs_wait_sum.sv
module pcs_wait_sum #(
    parameter int unsigned BASE_W    = 4,
    parameter int unsigned EXTRA_W   = 6,
    parameter int unsigned EXTRA_MAX = 50,
    parameter int unsigned SUM_W     = 7
) (
    input  logic [BASE_W-1:0]  base_wait,
    input  logic [EXTRA_W-1:0] extra_wait,
    output logic [SUM_W-1:0]   total_wait
);
    localparam logic [EXTRA_W-1:0] LIMIT = EXTRA_W'(EXTRA_MAX);

    logic [EXTRA_W-1:0] extra_lim;

    always_comb begin
        extra_lim  = (extra_wait > LIMIT) ? LIMIT : extra_wait;
        total_wait = SUM_W'(base_wait) + SUM_W'(extra_lim);
    end
endmodule

// File: rtl/pcs_strobe_decode.sv
module pcs_strobe_decode
    import pcs_pkg::*;
(
    input  phase_e  phase,
    input  logic    is_write,
    input  logic    is_io,
    input  logic    is_wide,
    input  logic    addr_lsb,
    output strobe_t lines
);
    logic enable_win;
    logic cmd_win;
    logic addr_win;

    always_comb begin
        enable_win = (phase == PH_STROBE) || (phase == PH_HOLD);
        cmd_win    = (phase == PH_STROBE);
        addr_win   = (phase == PH_SETUP) || enable_win;

        lines.ce_lo  = enable_win && (is_wide || !addr_lsb);
        lines.ce_hi  = enable_win && (is_wide || addr_lsb);
        lines.oe     = cmd_win && !is_io && !is_write;
        lines.we     = cmd_win && !is_io && is_write;
        lines.iord   = cmd_win && is_io && !is_write;
        lines.iowr   = cmd_win && is_io && is_write;
        lines.regsel = addr_win && is_io;
    end
endmodule

// File: rtl/pcard_strobe_seq.sv
module pcard_strobe_seq
    import pcs_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned SETUP_W   = 4,
    parameter int unsigned BASE_W    = 4,
    parameter int unsigned EXTRA_W   = 6,
    parameter int unsigned EXTRA_MAX = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_io,
    input  logic               req_wide,
    input  logic [AW-1:0]      req_addr,
    input  logic [15:0]        req_wdata,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic [SETUP_W-1:0] cfg_hold,
    input  logic [BASE_W-1:0]  cfg_base_wait,
    input  logic [EXTRA_W-1:0] cfg_extra_wait,
    input  logic               card_ready,
    input  logic [15:0]        card_rdata,
    output logic               busy,
    output logic               done,
    output logic [AW-1:0]      card_addr,
    output logic [15:0]        card_wdata,
    output logic               ce_lo_n,
    output logic               ce_hi_n,
    output logic               oe_n,
    output logic               we_n,
    output logic               iord_n,
    output logic               iowr_n,
    output logic               reg_n,
    output logic [15:0]        rdata
);
    localparam int unsigned WAIT_CAP = (1 << BASE_W) - 1 + EXTRA_MAX;
    localparam int unsigned SUM_W    = $clog2(WAIT_CAP + 1);
    localparam int unsigned CNT_W    = (SUM_W > SETUP_W) ? SUM_W : SETUP_W;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [AW-1:0]      addr;
        logic [DW-1:0]      wdata;
        logic               wr;
        logic               io;
        logic               wide;
        logic [SETUP_W-1:0] hold;
        logic [SUM_W-1:0]   total;
        logic [DW-1:0]      rdata;
        strobe_t            lines;
    } state_t;

    state_t q, d;
    logic [SUM_W-1:0] total_w;
    strobe_t lines_d;

    pcs_wait_sum #(
        .BASE_W   (BASE_W),
        .EXTRA_W  (EXTRA_W),
        .EXTRA_MAX(EXTRA_MAX),
        .SUM_W    (SUM_W)
    ) u_sum (
        .base_wait (cfg_base_wait),
        .extra_wait(cfg_extra_wait),
        .total_wait(total_w)
    );

    // decode is applied to next-state values so the lines leave flip-flops
    pcs_strobe_decode u_dec (
        .phase   (d.phase),
        .is_write(d.wr),
        .is_io   (d.io),
        .is_wide (d.wide),
        .addr_lsb(d.addr[0]),
        .lines   (lines_d)
    );

    always_comb begin
        d       = q;
        d.lines = '0;
        unique case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.wr    = req_write;
                    d.io    = req_io;
                    d.wide  = req_wide;
                    d.hold  = cfg_hold;
                    d.total = total_w;
                    if (cfg_setup != '0) begin
                        d.phase = PH_SETUP;
                        d.cnt   = CNT_W'(cfg_setup) - CNT_W'(1);
                    end else begin
                        d.phase = PH_STROBE;
                        d.cnt   = CNT_W'(total_w);
                    end
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.phase = PH_STROBE;
                    d.cnt   = CNT_W'(q.total);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else if ((q.total == '0) || card_ready) begin
                    if (!q.wr) begin
                        d.rdata = card_rdata;
                    end
                    if (q.hold != '0) begin
                        d.phase = PH_HOLD;
                        d.cnt   = CNT_W'(q.hold) - CNT_W'(1);
                    end else begin
                        d.phase = PH_DONE;
                    end
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) begin
                    d.phase = PH_DONE;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            PH_DONE: begin
                d.phase = PH_IDLE;
            end
            default: begin
                d.phase = PH_IDLE;
            end
        endcase
        d.lines = lines_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.phase != PH_IDLE);
    assign done       = (q.phase == PH_DONE);
    assign card_addr  = q.addr;
    assign card_wdata = q.wdata;
    assign rdata      = q.rdata;
    assign ce_lo_n    = ~q.lines.ce_lo;
    assign ce_hi_n    = ~q.lines.ce_hi;
    assign oe_n       = ~q.lines.oe;
    assign we_n       = ~q.lines.we;
    assign iord_n     = ~q.lines.iord;
    assign iowr_n     = ~q.lines.iowr;
    assign reg_n      = ~q.lines.regsel;
endmodule

// File: rtl/pcs_strobe_checker.sv
module pcs_strobe_checker #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] card_addr,
    input logic          ce_lo_n,
    input logic          ce_hi_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          iord_n,
    input logic          iowr_n,
    input logic          reg_n
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && ce_lo_n && ce_hi_n && oe_n && we_n
                    && iord_n && iowr_n && reg_n))
        else $error("a_r1_reset_quiet");

    a_r4_one_command: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~oe_n, ~we_n, ~iord_n, ~iowr_n}))
        else $error("a_r4_one_command");

    a_r6_cmd_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n || !iord_n || !iowr_n) |-> (!ce_lo_n || !ce_hi_n))
        else $error("a_r6_cmd_inside_ce");

    a_r5_io_regsel: assert property (@(posedge clk) disable iff (!rst_n)
        (!iord_n || !iowr_n) |-> !reg_n)
        else $error("a_r5_io_regsel");

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy))
        else $error("a_r9_done_single");

    a_r9_done_ce_off: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ce_lo_n && ce_hi_n && reg_n))
        else $error("a_r9_done_ce_off");

    a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(card_addr))
        else $error("a_r11_addr_stable");

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ce_lo_n && ce_hi_n && oe_n && we_n && iord_n && iowr_n))
        else $error("a_r1_idle_quiet");
endmodule

bind pcard_strobe_seq pcs_strobe_checker #(.AW(AW)) u_pcs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .card_addr(card_addr),
    .ce_lo_n  (ce_lo_n),
    .ce_hi_n  (ce_hi_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .iord_n   (iord_n),
    .iowr_n   (iowr_n),
    .reg_n    (reg_n)
);

// File: tb/tb_pcard_strobe_seq.sv
`timescale 1ns/1ps
module tb_pcard_strobe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_wide = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  cfg_setup = '0, cfg_hold = '0, cfg_base_wait = '0;
    logic [5:0]  cfg_extra_wait = '0;
    logic        card_ready = 1'b1;
    logic [15:0] card_rdata = '0;
    logic        busy, done, ce_lo_n, ce_hi_n, oe_n, we_n, iord_n, iowr_n, reg_n;
    logic [15:0] card_addr, card_wdata, rdata;

    pcard_strobe_seq dut (.*);

    always #2 clk = ~clk;

    int    n_checks = 0, n_fail = 0, cyc = 0, rdy_mode = 0;
    string scen = "R1";
    bit    finished = 1'b0;

    // reference model: a queue of phase codes built at acceptance
    // 1 setup, 2 strobe, 3 last strobe, 4 hold, 5 done
    int          sched[$];
    logic [15:0] m_addr = '0, m_wdata = '0, m_rdata = '0;
    logic        m_wr = 1'b0, m_io = 1'b0, m_wide = 1'b0;
    int          m_tot = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sched.delete();
            m_addr = '0; m_wdata = '0; m_rdata = '0;
            m_wr = 1'b0; m_io = 1'b0; m_wide = 1'b0; m_tot = 0;
        end else if (sched.size() == 0) begin
            if (req_valid) begin
                m_addr = req_addr; m_wdata = req_wdata;
                m_wr = req_write; m_io = req_io; m_wide = req_wide;
                m_tot = int'(cfg_base_wait) + ((cfg_extra_wait > 6'd50) ? 50 : int'(cfg_extra_wait));
                for (int i = 0; i < int'(cfg_setup); i++) sched.push_back(1);
                for (int i = 0; i < m_tot; i++) sched.push_back(2);
                sched.push_back(3);
                for (int i = 0; i < int'(cfg_hold); i++) sched.push_back(4);
                sched.push_back(5);
            end
        end else begin
            if (!(sched[0] == 3 && m_tot != 0 && !card_ready)) begin
                if (sched[0] == 3 && !m_wr) m_rdata = card_rdata;
                void'(sched.pop_front());
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] cyc %0d: got %h expected %h", tag, scen, cyc, act, exp);
        end
    endtask

    // stimulus on the falling edge, comparison on the falling edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        card_rdata <= 16'(cyc * 37 + 5);
        card_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 == 0) : 1'b0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int  p;
            bit  act, strb;
            p    = (sched.size() != 0) ? sched[0] : 0;
            act  = (p == 2 || p == 3 || p == 4);
            strb = (p == 2 || p == 3);
            chk("R6 busy", {31'd0, busy}, {31'd0, p != 0});
            chk("R9 done", {31'd0, done}, {31'd0, p == 5});
            chk("R3 ce_lo_n", {31'd0, ce_lo_n}, {31'd0, !(act && (m_wide || !m_addr[0]))});
            chk("R3 ce_hi_n", {31'd0, ce_hi_n}, {31'd0, !(act && (m_wide || m_addr[0]))});
            chk("R4 oe_n", {31'd0, oe_n}, {31'd0, !(strb && !m_io && !m_wr)});
            chk("R4 we_n", {31'd0, we_n}, {31'd0, !(strb && !m_io && m_wr)});
            chk("R5 iord_n", {31'd0, iord_n}, {31'd0, !(strb && m_io && !m_wr)});
            chk("R5 iowr_n", {31'd0, iowr_n}, {31'd0, !(strb && m_io && m_wr)});
            chk("R5 reg_n", {31'd0, reg_n}, {31'd0, !(m_io && p >= 1 && p <= 4)});
            chk("R2 card_addr", {16'd0, card_addr}, {16'd0, m_addr});
            chk("R11 card_wdata", {16'd0, card_wdata}, {16'd0, m_wdata});
            chk("R10 rdata", {16'd0, rdata}, {16'd0, m_rdata});
        end
    end

    task automatic run(input string s, input bit wr, input bit io, input bit wide,
                       input logic [15:0] addr, input logic [3:0] su, input logic [3:0] ho,
                       input logic [3:0] ba, input logic [5:0] ex, input int rmode, input bit poke);
        scen = s;
        @(negedge clk);
        rdy_mode = rmode;
        req_write = wr; req_io = io; req_wide = wide;
        req_addr = addr; req_wdata = addr ^ 16'h5a5a;
        cfg_setup = su; cfg_hold = ho; cfg_base_wait = ba; cfg_extra_wait = ex;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // change configuration mid-access: sampled values must stay in force (R2, R8)
        cfg_setup = ~su; cfg_hold = ~ho; cfg_base_wait = ~ba; cfg_extra_wait = ~ex;
        if (poke) begin
            req_valid = 1'b1; req_addr = ~addr; req_write = ~wr; req_io = ~io;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        chk("R9 idle after done", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset strobes", {25'd0, ce_lo_n, ce_hi_n, oe_n, we_n, iord_n, iowr_n, reg_n}, 32'h7f);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {24'd0, done, ce_lo_n, ce_hi_n, oe_n, we_n, iord_n, iowr_n, reg_n}, 32'h7f);

        run("R4 mem read even byte", 0, 0, 0, 16'h1234, 4'd2, 4'd1, 4'd1, 6'd0, 0, 0);
        run("R7 mem write odd byte, zero wait, ready low", 1, 0, 0, 16'h2345, 4'd0, 4'd0, 4'd0, 6'd0, 2, 0);
        run("R7 io read wide with ready stalls", 0, 1, 1, 16'h3456, 4'd3, 4'd2, 4'd2, 6'd3, 1, 0);
        run("R6 io write odd byte, extra clamp 63", 1, 1, 0, 16'h4567, 4'd15, 4'd15, 4'd15, 6'd63, 0, 0);
        run("R11 mem read wide with busy request", 0, 0, 1, 16'h5678, 4'd3, 4'd2, 4'd1, 6'd1, 0, 1);
        run("R6 mem write wide extra 50", 1, 0, 1, 16'h6788, 4'd1, 4'd0, 4'd0, 6'd50, 0, 0);
        run("R8 io read even byte hold only", 0, 1, 0, 16'h789a, 4'd0, 4'd7, 4'd0, 6'd2, 1, 0);
        run("R10 mem write keeps rdata", 1, 0, 0, 16'h89ab, 4'd1, 4'd3, 4'd2, 6'd0, 1, 0);
        run("R2 back-to-back zero setup", 0, 0, 0, 16'h9abd, 4'd0, 4'd0, 4'd0, 6'd51, 1, 1);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog [%s]: got hung run expected completion", scen);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule